// File: doc/BRIEF.md
# Host Data Bus Buffer Interface

This block sits between a host bus and a small embedded controller core. It holds one byte passed from the host to the core and one byte passed from the core to the host. An 8-bit status register is visible to both sides. The host uses a chip select, read and write strobes, and one address bit. With that bit at 0 the host reaches the data byte; with it at 1 it reaches the status register. On a write, the same bit tells the core whether the byte is a command or data.

The core moves bytes with two strobes. One loads the outgoing byte and the other consumes the incoming byte. The core can also clear or complement a general flag, and it can load the upper status nibble with its own meaning. A status bit copies the F0 flag of the core's program status word whenever the core updates that word. Hardware-managed "full" flags let each side see when a byte is waiting for it.

Status bit positions: bit 0 is output-full, bit 1 is input-full, bit 2 is the F0 copy, bit 3 is the command/data flag F1, and bits 7:4 belong to the core.

Top module: `hostbuf_iface`

## Requirements
- R1: After reset all eight status bits, the incoming byte and the outgoing byte are 0.
- R2: A core output-write strobe loads the outgoing byte and sets status bit 0 on the next clock edge.
- R3: A selected host read with the address bit at 0 presents the outgoing byte on host_rdata and clears status bit 0 at the next edge. If the core writes in the same cycle, bit 0 ends up set.
- R4: A selected host read with the address bit at 1 presents the status register and changes no state.
- R5: A selected host write stores the byte, sets status bit 1, and loads status bit 3 with the address bit (1 = command, 0 = data).
- R6: A core input-read strobe clears status bit 1, and core_ibuf_data always shows the last byte the host wrote. If a host write happens in the same cycle, bit 1 ends up set.
- R7: When the core's F0 update strobe is high, status bit 2 takes the value of core_f0 at the next edge; otherwise bit 2 holds.
- R8: The core's F1 clear forces bit 3 to 0, and F1 complement inverts it. Clear wins over complement, and a host write in the same cycle wins over both.
- R9: A core status write replaces bits 7:4 with core_sts_nib and leaves bits 3:0 unchanged.
- R10: Host strobes with host_sel low have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host chip select, active high |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_a0 | input | 1 | Host address bit: 0 data, 1 status/command |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Outgoing byte (a0=0) or status (a0=1), combinational |
| core_obuf_wr | input | 1 | Core loads the outgoing byte |
| core_obuf_data | input | 8 | Byte written by the core |
| core_ibuf_rd | input | 1 | Core consumes the incoming byte |
| core_ibuf_data | output | 8 | Last byte written by the host |
| core_f0_upd | input | 1 | Core program status word F0 changed |
| core_f0 | input | 1 | New F0 value |
| core_f1_clr | input | 1 | Clear F1 |
| core_f1_cpl | input | 1 | Complement F1 |
| core_sts_wr | input | 1 | Core writes the upper status nibble |
| core_sts_nib | input | 4 | Value for status bits 7:4 |
| core_status | output | 8 | Status register as the core sees it |

## Verification
On every cycle, the assertions check the single-event flag rules:
- an output write sets output-full,
- a data read with no competing write clears it,
- a host write sets input-full and copies the address bit,
- an input read alone clears input-full,
- a nibble write leaves the low nibble untouched,
- status reads and unselected strobes leave every register steady.

Only the bench's scenarios can show the priority outcomes of colliding events, the exact bytes on both read paths, and the F1 clear-versus-complement order. The bench sweeps every combination of the ten control inputs against an arithmetic model to expose those cases.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;
  localparam int OBF_BIT = 0;
  localparam int IBF_BIT = 1;
  localparam int F0_BIT  = 2;
  localparam int F1_BIT  = 3;
  localparam int LOW_W   = 4;

  typedef struct packed {
    logic wr;       // selected host write
    logic rd_data;  // selected host read of the data byte
    logic rd_sts;   // selected host read of status
  } host_ev_t;
endpackage

// File: rtl/hbuf_host_decode.sv
module hbuf_host_decode
  import hbuf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     host_sel,
  input  logic     host_rd,
  input  logic     host_wr,
  input  logic     host_a0,
  output host_ev_t ev
);
  always_comb begin
    ev.wr      = host_sel & host_wr;
    ev.rd_data = host_sel & host_rd & ~host_a0;
    ev.rd_sts  = host_sel & host_rd & host_a0;
  end

  // R10
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_sel |-> (ev == '0));
endmodule

// File: rtl/hbuf_byte_reg.sv
module hbuf_byte_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/hbuf_status.sv
module hbuf_status
  import hbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int HI_W  = DATA_W - LOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  host_ev_t          ev,
  input  logic              host_a0,
  input  logic              core_obuf_wr,
  input  logic              core_ibuf_rd,
  input  logic              core_f0_upd,
  input  logic              core_f0,
  input  logic              core_f1_clr,
  input  logic              core_f1_cpl,
  input  logic              core_sts_wr,
  input  logic [HI_W-1:0]   core_sts_nib,
  output logic [DATA_W-1:0] sts
);
  logic            obf_q, ibf_q, f0_q, f1_q;
  logic            obf_d, ibf_d, f0_d, f1_d;
  logic [HI_W-1:0] hi_q, hi_d;

  always_comb begin
    // Output-full: core set wins over host clear.
    obf_d = obf_q;
    if (core_obuf_wr)    obf_d = 1'b1;
    else if (ev.rd_data) obf_d = 1'b0;

    // Input-full: host set wins over core clear.
    ibf_d = ibf_q;
    if (ev.wr)             ibf_d = 1'b1;
    else if (core_ibuf_rd) ibf_d = 1'b0;

    f0_d = f0_q;
    if (core_f0_upd) f0_d = core_f0;

    // F1: host write, then clear, then complement.
    f1_d = f1_q;
    if (ev.wr)            f1_d = host_a0;
    else if (core_f1_clr) f1_d = 1'b0;
    else if (core_f1_cpl) f1_d = ~f1_q;

    hi_d = hi_q;
    if (core_sts_wr) hi_d = core_sts_nib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf_q <= 1'b0;
      ibf_q <= 1'b0;
      f0_q  <= 1'b0;
      f1_q  <= 1'b0;
      hi_q  <= '0;
    end else begin
      obf_q <= obf_d;
      ibf_q <= ibf_d;
      f0_q  <= f0_d;
      f1_q  <= f1_d;
      hi_q  <= hi_d;
    end
  end

  always_comb begin
    sts          = '0;
    sts[OBF_BIT] = obf_q;
    sts[IBF_BIT] = ibf_q;
    sts[F0_BIT]  = f0_q;
    sts[F1_BIT]  = f1_q;
    sts[DATA_W-1:LOW_W] = hi_q;
  end

  // R2
  obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_obuf_wr |=> sts[OBF_BIT]);
  // R3
  obf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.rd_data && !core_obuf_wr) |=> !sts[OBF_BIT]);
  // R5
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.wr |=> (sts[IBF_BIT] && (sts[F1_BIT] == $past(host_a0))));
  // R6
  ibf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ibuf_rd && !ev.wr) |=> !sts[IBF_BIT]);
  // R7
  f0_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_f0_upd |=> (sts[F0_BIT] == $past(core_f0)));
  // R9
  nib_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_sts_wr && !ev.wr && !ev.rd_data && !core_obuf_wr && !core_ibuf_rd &&
     !core_f0_upd && !core_f1_clr && !core_f1_cpl)
    |=> (sts[LOW_W-1:0] == $past(sts[LOW_W-1:0])));
endmodule

// File: rtl/hostbuf_iface.sv
module hostbuf_iface
  import hbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int HI_W  = DATA_W - LOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_a0,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              core_obuf_wr,
  input  logic [DATA_W-1:0] core_obuf_data,
  input  logic              core_ibuf_rd,
  output logic [DATA_W-1:0] core_ibuf_data,
  input  logic              core_f0_upd,
  input  logic              core_f0,
  input  logic              core_f1_clr,
  input  logic              core_f1_cpl,
  input  logic              core_sts_wr,
  input  logic [HI_W-1:0]   core_sts_nib,
  output logic [DATA_W-1:0] core_status
);
  host_ev_t          ev;
  logic [DATA_W-1:0] obuf_q, ibuf_q, sts;

  hbuf_host_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_sel (host_sel),
    .host_rd  (host_rd),
    .host_wr  (host_wr),
    .host_a0  (host_a0),
    .ev       (ev)
  );

  hbuf_byte_reg #(.W(DATA_W)) u_ibuf (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ev.wr),
    .d     (host_wdata),
    .q     (ibuf_q)
  );

  hbuf_byte_reg #(.W(DATA_W)) u_obuf (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (core_obuf_wr),
    .d     (core_obuf_data),
    .q     (obuf_q)
  );

  hbuf_status #(.DATA_W(DATA_W)) u_sts (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev           (ev),
    .host_a0      (host_a0),
    .core_obuf_wr (core_obuf_wr),
    .core_ibuf_rd (core_ibuf_rd),
    .core_f0_upd  (core_f0_upd),
    .core_f0      (core_f0),
    .core_f1_clr  (core_f1_clr),
    .core_f1_cpl  (core_f1_cpl),
    .core_sts_wr  (core_sts_wr),
    .core_sts_nib (core_sts_nib),
    .sts          (sts)
  );

  assign host_rdata     = host_a0 ? sts : obuf_q;
  assign core_ibuf_data = ibuf_q;
  assign core_status    = sts;

  logic core_quiet;
  assign core_quiet = !core_obuf_wr && !core_ibuf_rd && !core_f0_upd &&
                      !core_f1_clr && !core_f1_cpl && !core_sts_wr;

  // R4
  sts_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.rd_sts && !ev.wr && core_quiet)
    |=> ($stable(core_status) && $stable(core_ibuf_data)));
  // R10
  unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_sel && core_quiet)
    |=> ($stable(core_status) && $stable(core_ibuf_data)));
endmodule

// File: tb/sim_hostbuf_iface.sv
`timescale 1ns/1ps
module sim_hostbuf_iface;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_sel, host_rd, host_wr, host_a0;
  logic [7:0] host_wdata, host_rdata;
  logic       core_obuf_wr, core_ibuf_rd, core_f0_upd, core_f0;
  logic       core_f1_clr, core_f1_cpl, core_sts_wr;
  logic [7:0] core_obuf_data, core_ibuf_data, core_status;
  logic [3:0] core_sts_nib;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // expected state
  logic [7:0] e_obuf, e_ibuf;
  logic       e_obf, e_ibf, e_f0, e_f1;
  logic [3:0] e_hi;

  always #5 clk = ~clk;

  hostbuf_iface u0 (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr),
    .host_a0(host_a0), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_obuf_wr(core_obuf_wr), .core_obuf_data(core_obuf_data),
    .core_ibuf_rd(core_ibuf_rd), .core_ibuf_data(core_ibuf_data),
    .core_f0_upd(core_f0_upd), .core_f0(core_f0),
    .core_f1_clr(core_f1_clr), .core_f1_cpl(core_f1_cpl),
    .core_sts_wr(core_sts_wr), .core_sts_nib(core_sts_nib),
    .core_status(core_status)
  );

  function automatic logic [7:0] e_sts();
    return {e_hi, e_f1, e_f0, e_ibf, e_obf};
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check8({tag, " status"}, core_status, e_sts());
    check8({tag, " incoming byte"}, core_ibuf_data, e_ibuf);
  endtask

  // c bits: 0 sel,1 wr,2 rd,3 a0,4 ibuf_rd,5 obuf_wr,6 f1_clr,7 f1_cpl,8 f0_upd,9 sts_wr
  task automatic step(input logic [9:0] c, input logic [7:0] wd, input logic [7:0] od,
                      input logic [3:0] nib, input logic f0v, input string tag);
    logic hw, hr;
    host_sel = c[0]; host_wr = c[1]; host_rd = c[2]; host_a0 = c[3];
    core_ibuf_rd = c[4]; core_obuf_wr = c[5]; core_f1_clr = c[6];
    core_f1_cpl = c[7]; core_f0_upd = c[8]; core_sts_wr = c[9];
    host_wdata = wd; core_obuf_data = od; core_sts_nib = nib; core_f0 = f0v;
    #1;
    check8({tag, " host read path"}, host_rdata, c[3] ? e_sts() : e_obuf);
    hw = c[0] & c[1];
    hr = c[0] & c[2] & ~c[3];
    @(posedge clk);
    if (c[5]) e_obuf = od;
    e_obf = c[5] ? 1'b1 : (hr ? 1'b0 : e_obf);
    if (hw) e_ibuf = wd;
    e_ibf = hw ? 1'b1 : (c[4] ? 1'b0 : e_ibf);
    e_f1  = hw ? c[3] : (c[6] ? 1'b0 : (c[7] ? ~e_f1 : e_f1));
    if (c[8]) e_f0 = f0v;
    if (c[9]) e_hi = nib;
    @(negedge clk);
    check_state(tag);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    host_sel = 0; host_rd = 0; host_wr = 0; host_a0 = 0; host_wdata = 8'h00;
    core_obuf_wr = 0; core_ibuf_rd = 0; core_f0_upd = 0; core_f0 = 0;
    core_f1_clr = 0; core_f1_cpl = 0; core_sts_wr = 0; core_sts_nib = 4'h0;
    core_obuf_data = 8'h00;
    e_obuf = 0; e_ibuf = 0; e_obf = 0; e_ibf = 0; e_f0 = 0; e_f1 = 0; e_hi = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_state("R1");
    check8("R1 outgoing byte", host_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 core loads outgoing byte
    step(10'b0000100000, 8'h00, 8'hA5, 4'h0, 1'b0, "R2");
    // R3 host data read clears output-full
    step(10'b0000000101, 8'h00, 8'h00, 4'h0, 1'b0, "R3");
    // R3 read colliding with a new core write
    step(10'b0000100101, 8'h00, 8'h5A, 4'h0, 1'b0, "R3 collide");
    // R4 status read has no effect
    step(10'b0000001101, 8'h00, 8'h00, 4'h0, 1'b0, "R4");
    // R5 command write then data write
    step(10'b0000001011, 8'h3C, 8'h00, 4'h0, 1'b0, "R5 command");
    step(10'b0000000011, 8'hC3, 8'h00, 4'h0, 1'b0, "R5 data");
    // R6 core consumes, then collision with host write
    step(10'b0000010000, 8'h00, 8'h00, 4'h0, 1'b0, "R6");
    step(10'b0000011011, 8'h77, 8'h00, 4'h0, 1'b0, "R6 collide");
    // R7 F0 copy, set then clear, plus hold
    step(10'b0100000000, 8'h00, 8'h00, 4'h0, 1'b1, "R7 set");
    step(10'b0000000000, 8'h00, 8'h00, 4'h0, 1'b0, "R7 hold");
    step(10'b0100000000, 8'h00, 8'h00, 4'h0, 1'b0, "R7 clear");
    // R8 F1 ops and priorities
    step(10'b0010000000, 8'h00, 8'h00, 4'h0, 1'b0, "R8 complement");
    step(10'b0011000000, 8'h00, 8'h00, 4'h0, 1'b0, "R8 clear beats complement");
    step(10'b0001001011, 8'h11, 8'h00, 4'h0, 1'b0, "R8 host beats clear");
    // R9 nibble writes, all values
    for (int n = 0; n < 16; n++)
      step(10'b1000000000, 8'h00, 8'h00, n[3:0], 1'b0, "R9");
    // R10 unselected strobes
    step(10'b0000001110, 8'hEE, 8'h00, 4'h0, 1'b0, "R10 status");
    step(10'b0000000110, 8'hDD, 8'h00, 4'h0, 1'b0, "R10 data");
    // byte sweep through both paths
    for (int b = 0; b < 256; b++) begin
      step(10'b0000100000, 8'h00, b[7:0], 4'h0, 1'b0, "R2 sweep");
      step(10'b0000000111, ~b[7:0], 8'h00, 4'h0, 1'b0, "R3 R5 sweep");
    end
    // full control sweep
    for (int v = 0; v < 1024; v++)
      step(v[9:0], 8'(v * 7 + 3), 8'(v * 13 + 5), 4'(v >> 3), v[3] ^ v[6],
           "R8 control sweep");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule